// File: doc/BRIEF.md
# Receive Packet Latency Flush Timer

This block decides when bytes waiting in a device-to-host receive buffer are handed to the packet sender. A packet goes out at once when the buffer holds at least one maximum-size packet. Otherwise a latency timer, counted in milliseconds, forces the partial contents out as a short packet when it runs out. The timer is reloaded every time a packet is issued. It stands still while the buffer is empty, so an empty buffer never produces a zero-length packet.

The latency setting is an 8-bit number of milliseconds (0 to 255) and comes out of reset at 16. A written value is held as pending and becomes active only at the next timer reload. A setting of 0 switches the block to per-microframe flushing: any buffered data is offered on every high-speed microframe tick, and the millisecond tick is ignored. Microframe and millisecond ticks arrive as single-cycle strobes from the bus timing logic; eight microframes make one millisecond. The buffer behind the block holds 4096 bytes.

Top module: `lft_flush_timer`

## Requirements
- R1: After reset the send strobe and the reload acknowledge are low, and the active latency is 16 ms.
- R2: When the buffer count is at least the nonzero maximum packet size, the send strobe is high in the next cycle with a length equal to the maximum packet size, whatever the timer holds.
- R3: With a nonzero latency N, a buffer count between 1 and max-1 is flushed as a short packet, with length equal to the count, on the Nth millisecond tick after the last reload. A send never happens in a cycle after one that had no tick and no full buffer.
- R4: Millisecond ticks that arrive while the buffer count is 0 do not advance the timer.
- R5: Every issued packet reloads the timer, and the reload acknowledge pulses in the same cycle as the send strobe.
- R6: With an active latency of 0, every microframe tick with a nonzero count gives a short packet in the next cycle, and millisecond ticks cause no send.
- R7: No packet is ever sent with length 0, and an empty buffer never causes a send, in either latency mode.
- R8: A latency write takes effect only at the next reload. A write in the same cycle as a reload waits for the reload after that.
- R9: When a timeout expiry and a full buffer fall in the same cycle, exactly one packet is sent and its length is the maximum packet size.
- R10: The largest setting, 255, expires on the 255th millisecond tick and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | One-cycle strobe per 125 us microframe |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| buf_count | input | 13 | Bytes currently in the receive buffer (0 to 4096) |
| max_pkt | input | 11 | Maximum packet size in bytes |
| lat_wr | input | 1 | Write strobe for a new latency setting |
| lat_val | input | 8 | Latency setting in ms; 0 selects per-microframe flushing |
| send_pkt | output | 1 | One-cycle strobe: issue a packet now |
| send_len | output | 11 | Length of the packet issued with send_pkt |
| tmr_ack | output | 1 | Pulses when the timer is reloaded |

## Verification
Timeout expiry and the full-packet decision can land in the same cycle. The bench arms a 1 ms latency with a short count pending, then raises the count past the maximum in the very cycle a millisecond tick arrives. It expects a single strobe carrying the maximum length, not the stale count. A second collision, a latency write in the cycle of a reload, is judged by counting ticks to the next two expiries.

// File: rtl/lft_pkg.sv
package lft_pkg;
    localparam int BUF_BYTES   = 4096;
    localparam int CNT_W       = $clog2(BUF_BYTES + 1);
    localparam int PKT_W       = 11;
    localparam int LAT_W       = 8;
    localparam int LAT_DEFAULT = 16;

    typedef struct packed {
        logic             send;
        logic [PKT_W-1:0] len;
        logic             ack;
    } out_t;

    typedef struct packed {
        logic [LAT_W-1:0] pend;
        logic [LAT_W-1:0] act;
    } lat_t;
endpackage

// File: rtl/lft_latency_reg.sv
module lft_latency_reg
    import lft_pkg::*;
#(
    parameter int W   = LAT_W,
    parameter int DEF = LAT_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] val,
    input  logic         reload,
    output logic [W-1:0] pend,
    output logic         zero_mode
);
    localparam logic [W-1:0] DEF_V = W'(DEF);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // reload consumes the pending value as it stood before this cycle
        if (reload) st_d.act = st_q.pend;
        if (wr)     st_d.pend = val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= DEF_V;
            st_q.act  <= DEF_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend      = st_q.pend;
    assign zero_mode = (st_q.act == '0);
endmodule

// File: rtl/lft_timeout_ctr.sv
module lft_timeout_ctr
    import lft_pkg::*;
#(
    parameter int W   = LAT_W,
    parameter int DEF = LAT_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         uframe_tick,
    input  logic         ms_tick,
    input  logic         nonempty,
    input  logic         zero_mode,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    output logic         expire
);
    localparam logic [W-1:0] DEF_V = W'(DEF);
    localparam logic [W-1:0] ONE   = W'(1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         step_ms;

    always_comb begin
        step_ms = ms_tick && nonempty && !zero_mode;
        if (zero_mode) expire = uframe_tick && nonempty;
        else           expire = step_ms && (cnt_q <= ONE);

        cnt_d = cnt_q;
        if (reload)                      cnt_d = reload_val;
        else if (step_ms && cnt_q > ONE) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= DEF_V;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lft_packet_decide.sv
module lft_packet_decide
    import lft_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PKT_W
) (
    input  logic          expire,
    input  logic [CW-1:0] count,
    input  logic [PW-1:0] max_pkt,
    output logic          send,
    output logic [PW-1:0] len
);
    logic full;

    always_comb begin
        full = (max_pkt != '0) && (count >= CW'(max_pkt));
        send = full || (expire && count != '0);
        // full wins over a simultaneous expiry
        len  = full ? max_pkt : PW'(count);
    end
endmodule

// File: rtl/lft_flush_timer.sv
module lft_flush_timer
    import lft_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int PW  = PKT_W,
    parameter int LW  = LAT_W,
    parameter int DEF = LAT_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uframe_tick,
    input  logic          ms_tick,
    input  logic [CW-1:0] buf_count,
    input  logic [PW-1:0] max_pkt,
    input  logic          lat_wr,
    input  logic [LW-1:0] lat_val,
    output logic          send_pkt,
    output logic [PW-1:0] send_len,
    output logic          tmr_ack
);
    typedef struct packed {
        logic          send;
        logic [PW-1:0] len;
        logic          ack;
    } o_t;

    o_t            out_d, out_q;
    logic          send_c;
    logic [PW-1:0] len_c;
    logic          expire;
    logic          zero_mode;
    logic [LW-1:0] pend;

    lft_latency_reg #(.W(LW), .DEF(DEF)) u_lat (
        .clk(clk), .rst_n(rst_n), .wr(lat_wr), .val(lat_val),
        .reload(send_c), .pend(pend), .zero_mode(zero_mode)
    );

    lft_timeout_ctr #(.W(LW), .DEF(DEF)) u_ctr (
        .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick),
        .ms_tick(ms_tick), .nonempty(buf_count != '0),
        .zero_mode(zero_mode), .reload(send_c), .reload_val(pend),
        .expire(expire)
    );

    lft_packet_decide #(.CW(CW), .PW(PW)) u_dec (
        .expire(expire), .count(buf_count), .max_pkt(max_pkt),
        .send(send_c), .len(len_c)
    );

    always_comb begin
        out_d      = '0;
        out_d.send = send_c;
        out_d.len  = send_c ? len_c : '0;
        out_d.ack  = send_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign send_pkt = out_q.send;
    assign send_len = out_q.len;
    assign tmr_ack  = out_q.ack;
endmodule

// File: rtl/lft_flush_timer_chk.sv
module lft_flush_timer_chk
    import lft_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PKT_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uframe_tick,
    input logic          ms_tick,
    input logic [CW-1:0] buf_count,
    input logic [PW-1:0] max_pkt,
    input logic          send_pkt,
    input logic [PW-1:0] send_len,
    input logic          tmr_ack
);
    logic is_full;
    assign is_full = (max_pkt != '0) && (buf_count >= CW'(max_pkt));

    assert_full_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |=> (send_pkt && send_len == $past(max_pkt)));

    assert_tick_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_full && !ms_tick && !uframe_tick) |=> !send_pkt);

    assert_short_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_full && buf_count != '0) |=> (!send_pkt || send_len == PW'($past(buf_count))));

    assert_ack_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        send_pkt |-> tmr_ack);

    assert_no_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        send_pkt |-> (send_len != '0));

    assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_count == '0) |=> !send_pkt);
endmodule

bind lft_flush_timer lft_flush_timer_chk #(.CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .ms_tick(ms_tick),
    .buf_count(buf_count), .max_pkt(max_pkt), .send_pkt(send_pkt),
    .send_len(send_len), .tmr_ack(tmr_ack)
);

// File: tb/tb_lft_flush_timer.sv
module tb_lft_flush_timer;
    localparam int MAXP = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uframe_tick = 1'b0;
    logic        ms_tick = 1'b0;
    logic [12:0] buf_count = '0;
    logic [10:0] max_pkt = 11'(MAXP);
    logic        lat_wr = 1'b0;
    logic [7:0]  lat_val = '0;
    logic        send_pkt;
    logic [10:0] send_len;
    logic        tmr_ack;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lft_flush_timer dut (
        .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .ms_tick(ms_tick),
        .buf_count(buf_count), .max_pkt(max_pkt), .lat_wr(lat_wr),
        .lat_val(lat_val), .send_pkt(send_pkt), .send_len(send_len),
        .tmr_ack(tmr_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // n ms ticks with a quiet cycle between; reports sends and the first hit
    task automatic run_ticks(input int n, output int sends, output int first, output int len);
        sends = 0; first = 0; len = -1;
        for (int i = 1; i <= n; i++) begin
            ms_tick = 1'b1;
            step();
            ms_tick = 1'b0;
            if (send_pkt) begin
                sends++;
                if (first == 0) begin first = i; len = int'(send_len); end
            end
            step();
        end
    endtask

    task automatic write_lat(input int v);
        lat_val = 8'(v); lat_wr = 1'b1;
        step();
        lat_wr = 1'b0;
    endtask

    task automatic force_reload();
        buf_count = 13'(MAXP);
        step();
        buf_count = '0;
        step();
    endtask

    task automatic t_reset();
        chk("R1 send after reset", int'(send_pkt), 0);
        chk("R1 ack after reset", int'(tmr_ack), 0);
    endtask

    task automatic t_full();
        buf_count = 13'(MAXP);
        step();
        chk("R2 send at exact max", int'(send_pkt), 1);
        chk("R2 len at exact max", int'(send_len), MAXP);
        chk("R5 ack with full send", int'(tmr_ack), 1);
        buf_count = 13'(MAXP + 88);
        step();
        chk("R2 len above max", int'(send_len), MAXP);
        buf_count = '0;
        step();
        chk("R2 idle after drain", int'(send_pkt), 0);
    endtask

    task automatic t_short();
        int s, f, l;
        buf_count = 13'd5;
        run_ticks(16, s, f, l);
        chk("R1 default 16 ms expiry tick", f, 16);
        chk("R3 short sends", s, 1);
        chk("R3 short len", l, 5);
        buf_count = '0;
        step();
    endtask

    task automatic t_hold();
        int s, f, l;
        run_ticks(20, s, f, l);
        chk("R4 empty ticks no send", s, 0);
        buf_count = 13'd3;
        run_ticks(16, s, f, l);
        chk("R4 timer held while empty", f, 16);
        buf_count = '0;
        step();
    endtask

    task automatic t_restart();
        int s, f, l;
        buf_count = 13'd5;
        run_ticks(10, s, f, l);
        chk("R5 no early send", s, 0);
        buf_count = 13'(MAXP);
        step();
        chk("R5 ack on reload", int'(tmr_ack), 1);
        buf_count = 13'd5;
        step();
        run_ticks(16, s, f, l);
        chk("R5 full wait after restart", f, 16);
        buf_count = '0;
        step();
    endtask

    task automatic t_write();
        int s, f, l;
        write_lat(4);
        buf_count = 13'd2;
        run_ticks(16, s, f, l);
        chk("R8 old value until reload", f, 16);
        run_ticks(4, s, f, l);
        chk("R8 new value after reload", f, 4);
        buf_count = 13'(MAXP);
        lat_val = 8'd8; lat_wr = 1'b1;
        step();
        lat_wr = 1'b0;
        buf_count = 13'd2;
        run_ticks(4, s, f, l);
        chk("R8 same-cycle write deferred", f, 4);
        run_ticks(8, s, f, l);
        chk("R8 deferred write applied", f, 8);
        buf_count = '0;
        step();
    endtask

    task automatic t_max();
        int s, f, l;
        write_lat(255);
        force_reload();
        buf_count = 13'd1;
        run_ticks(255, s, f, l);
        chk("R10 255 ms expiry tick", f, 255);
        chk("R10 single send", s, 1);
        buf_count = '0;
        step();
    endtask

    task automatic t_prio();
        int s, f, l;
        write_lat(1);
        force_reload();
        buf_count = 13'd5;
        run_ticks(1, s, f, l);
        chk("R3 1 ms short len", l, 5);
        buf_count = 13'd700;
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
        buf_count = '0;
        chk("R9 collision send", int'(send_pkt), 1);
        chk("R9 collision len", int'(send_len), MAXP);
        step();
        chk("R9 single strobe", int'(send_pkt), 0);
    endtask

    task automatic t_zero();
        write_lat(0);
        force_reload();
        buf_count = 13'd3;
        uframe_tick = 1'b1;
        step();
        uframe_tick = 1'b0;
        chk("R6 microframe flush", int'(send_pkt), 1);
        chk("R6 microframe len", int'(send_len), 3);
        buf_count = '0;
        uframe_tick = 1'b1;
        step();
        uframe_tick = 1'b0;
        chk("R7 empty microframe no send", int'(send_pkt), 0);
        buf_count = 13'd3;
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
        chk("R6 ms tick ignored in zero mode", int'(send_pkt), 0);
        uframe_tick = 1'b1;
        step();
        uframe_tick = 1'b0;
        chk("R6 second microframe flush", int'(send_pkt), 1);
        buf_count = '0;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_full();
        t_short();
        t_hold();
        t_restart();
        t_write();
        t_max();
        t_prio();
        t_zero();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule